// File: doc/BRIEF.md
# Timestamp and Event Counter Register Unit

This unit keeps two hardware counters behind a simple register port: a 64-bit timestamp counter that advances once per clock, and a 40-bit event counter that advances on qualified event pulses. Software-side logic reaches both through one address bus, a 64-bit write data bus with a write strobe, and a read strobe whose 64-bit result comes back one clock later together with an error flag for addresses that hold no register.

The timestamp counter can be frozen by low-power and special processor modes. Each mode (bit 0 system-management, bit 1 debug, bit 2 suspend) has a level input that says the mode is active and a configuration bit that says counting must stop while it is. The event counter only steps when the pulse input and the external enable are both high. Writing the timestamp register keeps only the low half of the write data and clears the high half. The event register shows its 40 counter bits in bits 39:0, and its upper bits read as zero.

The read side is a three-state machine: `RD_IDLE` (no result on the bus), `RD_DATA` (captured register value on the bus) and `RD_ERR` (zero on the bus, error flag high). From any state, a read strobe at a mapped address goes to `RD_DATA`, a read strobe at an unmapped address goes to `RD_ERR`, and no read strobe goes to `RD_IDLE`.

Top module: `ctr_msr_unit`

## Requirements
- R1: After reset both counters hold zero, `rd_data` is zero and `rd_err` is low.
- R2: With no write to it and no inhibiting mode, the timestamp counter grows by exactly one per clock; a read returns the value held just before the clock edge that samples the read strobe.
- R3: A write at address 0x10 loads `wr_data[31:0]` into timestamp bits 31:0 and clears timestamp bits 63:32.
- R4: The timestamp counter holds its value in every cycle where some mode bit i has both `mode_active[i]` and `mode_hold[i]` high (bit 0 system-management, bit 1 debug, bit 2 suspend); an active mode whose hold bit is low, or a set hold bit whose mode is inactive, does not stop it.
- R5: The event counter grows by one in a cycle where `evt_pulse` and `evt_enable` are both high, and keeps its value when either is low.
- R6: A write at address 0xC1 loads `wr_data[39:0]` into the event counter and ignores `wr_data[63:40]`; a read at 0xC1 returns the counter in bits 39:0 and zero in bits 63:40.
- R7: Both counters wrap from all ones to zero with no other visible effect.
- R8: When a write and an increment reach the same counter in one cycle, the counter takes the written value and the increment is lost.
- R9: A read at any address other than 0x10 and 0xC1 returns zero with `rd_err` high for exactly the one cycle after the read strobe.
- R10: Read results appear exactly one cycle after `rd_en`; in any cycle not preceded by a read strobe, `rd_data` is zero and `rd_err` is low.
- R11: A write at an address other than 0x10 and 0xC1 changes neither counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears both counters and the read state |
| addr | input | 32 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Read result, valid the cycle after `rd_en` |
| rd_err | output | 1 | High the cycle after a read of an unmapped address |
| mode_active | input | 3 | Mode level inputs: bit 0 system-management, bit 1 debug, bit 2 suspend |
| mode_hold | input | 3 | Per-mode count-inhibit configuration bits, same bit order |
| evt_pulse | input | 1 | Event occurrence for the event counter |
| evt_enable | input | 1 | External enable from the event select logic |

## Verification
The timestamp counter is tried frozen under each mode with its own hold bit, running with a mode active but not configured to inhibit, and running with all hold bits set but no mode active, which separates a per-mode AND from a plain OR of either vector. Reads spaced by different idle gaps check the per-clock step and the one-cycle read latency against a counted number of edges. The event counter is driven with pulses both enabled and disabled, with a load of all ones followed by one pulse to show the wrap, and with a write coinciding with a pulse to show which one wins. Writes carrying nonzero upper data, and reads and writes at unmapped addresses, show that the reserved bits and stray accesses leave no trace.

// File: rtl/ctr_msr_pkg.sv
package ctr_msr_pkg;

    // Read-side states of the register port
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_DATA = 2'd1,
        RD_ERR  = 2'd2
    } rd_state_e;

    // Result of address decode
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TSC  = 2'd1,
        SEL_EVT  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/ctr_msr_decode.sv
module ctr_msr_decode
    import ctr_msr_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]  TSC_ADDR = 'h10,
    parameter logic [ADDR_W-1:0]  EVT_ADDR = 'hC1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if (addr == TSC_ADDR) begin
            sel = SEL_TSC;
        end else if (addr == EVT_ADDR) begin
            sel = SEL_EVT;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/ctr_msr_counter.sv
module ctr_msr_counter #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    // Load has priority over the step; the step wraps silently.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ctr_msr_gate.sv
module ctr_msr_gate #(
    parameter int unsigned NUM_MODES = 3
) (
    input  logic [NUM_MODES-1:0] mode_active,
    input  logic [NUM_MODES-1:0] mode_hold,
    output logic                 run
);

    logic [NUM_MODES-1:0] blocked;

    for (genvar i = 0; i < NUM_MODES; i++) begin : g_mode
        assign blocked[i] = mode_active[i] & mode_hold[i];
    end

    assign run = ~(|blocked);

endmodule

// File: rtl/ctr_msr_rdport.sv
module ctr_msr_rdport
    import ctr_msr_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] tsc_view,
    input  logic [DATA_W-1:0] evt_view,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err
);

    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [DATA_W-1:0] mux_val;
    logic [DATA_W-1:0] cap_q;

    always_comb begin
        unique case (sel)
            SEL_TSC: mux_val = tsc_view;
            SEL_EVT: mux_val = evt_view;
            default: mux_val = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = RD_IDLE;
        if (rd_en) begin
            state_d = (sel == SEL_NONE) ? RD_ERR : RD_DATA;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured read value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (rd_en) begin
            cap_q <= mux_val;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            RD_DATA: begin
                rd_data = cap_q;
                rd_err  = 1'b0;
            end
            RD_ERR: begin
                rd_data = '0;
                rd_err  = 1'b1;
            end
            default: begin
                rd_data = '0;
                rd_err  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctr_msr_unit.sv
module ctr_msr_unit
    import ctr_msr_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       DATA_W    = 64,
    parameter int unsigned       EVT_W     = 40,
    parameter int unsigned       NUM_MODES = 3,
    parameter logic [ADDR_W-1:0] TSC_ADDR  = 'h10,
    parameter logic [ADDR_W-1:0] EVT_ADDR  = 'hC1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_err,
    input  logic [NUM_MODES-1:0] mode_active,
    input  logic [NUM_MODES-1:0] mode_hold,
    input  logic                 evt_pulse,
    input  logic                 evt_enable
);

    localparam int unsigned LO_W  = DATA_W / 2;
    localparam int unsigned PAD_W = DATA_W - EVT_W;

    reg_sel_e          sel;
    logic              tsc_run;
    logic              tsc_load;
    logic              evt_load;
    logic              evt_inc;
    logic [DATA_W-1:0] tsc_load_val;
    logic [DATA_W-1:0] tsc_q;
    logic [EVT_W-1:0]  evt_q;
    logic [DATA_W-1:0] evt_view;

    ctr_msr_decode #(
        .ADDR_W   (ADDR_W),
        .TSC_ADDR (TSC_ADDR),
        .EVT_ADDR (EVT_ADDR)
    ) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    ctr_msr_gate #(
        .NUM_MODES (NUM_MODES)
    ) u_gate (
        .mode_active (mode_active),
        .mode_hold   (mode_hold),
        .run         (tsc_run)
    );

    assign tsc_load     = wr_en && (sel == SEL_TSC);
    assign evt_load     = wr_en && (sel == SEL_EVT);
    assign evt_inc      = evt_pulse && evt_enable;
    assign tsc_load_val = {{(DATA_W-LO_W){1'b0}}, wr_data[LO_W-1:0]};

    ctr_msr_counter #(
        .W (DATA_W)
    ) u_tsc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tsc_load),
        .load_val (tsc_load_val),
        .inc      (tsc_run),
        .cnt      (tsc_q)
    );

    ctr_msr_counter #(
        .W (EVT_W)
    ) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (evt_load),
        .load_val (wr_data[EVT_W-1:0]),
        .inc      (evt_inc),
        .cnt      (evt_q)
    );

    assign evt_view = {{PAD_W{1'b0}}, evt_q};

    ctr_msr_rdport #(
        .DATA_W (DATA_W)
    ) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (sel),
        .tsc_view (tsc_q),
        .evt_view (evt_view),
        .rd_data  (rd_data),
        .rd_err   (rd_err)
    );

endmodule

// File: rtl/ctr_msr_chk.sv
module ctr_msr_chk #(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       DATA_W    = 64,
    parameter int unsigned       EVT_W     = 40,
    parameter int unsigned       NUM_MODES = 3,
    parameter logic [ADDR_W-1:0] TSC_ADDR  = 'h10,
    parameter logic [ADDR_W-1:0] EVT_ADDR  = 'hC1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                 wr_en,
    input logic [DATA_W-1:0]    wr_data,
    input logic                 rd_en,
    input logic [DATA_W-1:0]    rd_data,
    input logic                 rd_err,
    input logic [NUM_MODES-1:0] mode_active,
    input logic [NUM_MODES-1:0] mode_hold,
    input logic                 evt_pulse,
    input logic                 evt_enable,
    input logic [DATA_W-1:0]    tsc_val,
    input logic [EVT_W-1:0]     evt_val
);

    localparam int unsigned LO_W = DATA_W / 2;

    logic hit_tsc, hit_evt, hit_any, wr_tsc, wr_evt, frozen, ev_step;

    assign hit_tsc = (addr == TSC_ADDR);
    assign hit_evt = (addr == EVT_ADDR);
    assign hit_any = hit_tsc || hit_evt;
    assign wr_tsc  = wr_en && hit_tsc;
    assign wr_evt  = wr_en && hit_evt;
    assign frozen  = |(mode_active & mode_hold);
    assign ev_step = evt_pulse && evt_enable;

    // R2: free-running step
    assert_tsc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_tsc) && !$past(frozen) |-> tsc_val == $past(tsc_val) + 1'b1);

    // R3: write clears the high half
    assert_tsc_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_tsc) |->
            tsc_val[DATA_W-1:LO_W] == '0 && tsc_val[LO_W-1:0] == $past(wr_data[LO_W-1:0]));

    // R4: inhibited mode freezes the timestamp
    assert_tsc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_tsc) && $past(frozen) |-> $stable(tsc_val));

    // R5: qualified event step and hold
    assert_evt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_evt) && $past(ev_step) |-> evt_val == $past(evt_val) + 1'b1);

    assert_evt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_en) && !$past(ev_step) |-> $stable(evt_val));

    // R6: reserved bits of an event read are zero
    assert_evt_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_en && hit_evt) |-> rd_data[DATA_W-1:EVT_W] == '0);

    // R7: event wrap
    assert_evt_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_evt) && $past(ev_step) && ($past(evt_val) == '1) |-> evt_val == '0);

    // R8: write beats increment
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_evt) |-> evt_val == $past(wr_data[EVT_W-1:0]));

    // R9: unmapped read
    assert_bad_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_en && !hit_any) |-> rd_err && rd_data == '0);

    // R10: mapped read carries no error; idle bus is quiet
    assert_good_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rd_en && hit_any) |-> !rd_err);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(rd_en) |-> !rd_err && rd_data == '0);

    // R11: stray write leaves the event counter alone
    assert_bad_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en && !hit_any) && !$past(ev_step) |-> $stable(evt_val));

endmodule

bind ctr_msr_unit ctr_msr_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .EVT_W     (EVT_W),
    .NUM_MODES (NUM_MODES),
    .TSC_ADDR  (TSC_ADDR),
    .EVT_ADDR  (EVT_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_err      (rd_err),
    .mode_active (mode_active),
    .mode_hold   (mode_hold),
    .evt_pulse   (evt_pulse),
    .evt_enable  (evt_enable),
    .tsc_val     (tsc_q),
    .evt_val     (evt_q)
);

// File: tb/sim_ctr_msr_unit.sv
`timescale 1ns/1ps
module sim_ctr_msr_unit;

    localparam logic [31:0] A_TSC = 32'h10;
    localparam logic [31:0] A_EVT = 32'hC1;

    typedef struct {
        logic [63:0] d;
        logic        e;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [63:0] rd_data;
    logic        rd_err;
    logic [2:0]  mode_active = 3'b001;
    logic [2:0]  mode_hold = 3'b001;
    logic        evt_pulse = 1'b0;
    logic        evt_enable = 1'b0;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sbq[$];

    always #2 clk = ~clk;

    ctr_msr_unit u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .rd_err      (rd_err),
        .mode_active (mode_active),
        .mode_hold   (mode_hold),
        .evt_pulse   (evt_pulse),
        .evt_enable  (evt_enable)
    );

    // Driver tasks: each consumes exactly one rising edge, entered and left at a falling edge.
    task automatic wr(input logic [31:0] a, input logic [63:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [63:0] d, input logic e, input string tag);
        exp_t it;
        it.d = d; it.e = e; it.tag = tag;
        sbq.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet(input string tag);
        checks++;
        if (rd_data !== 64'h0 || rd_err !== 1'b0) begin
            errors++;
            $display("FAIL %s: rd_data=%h rd_err=%b expected rd_data=0 rd_err=0", tag, rd_data, rd_err);
        end
    endtask

    // Monitor: pops one expected item for every read strobe seen at a rising edge.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en === 1'b1) begin
                @(negedge clk);
                checks++;
                if (sbq.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: result %h with no expected item, expected none", rd_data);
                end else begin
                    exp_t it;
                    it = sbq.pop_front();
                    if (rd_data !== it.d || rd_err !== it.e) begin
                        errors++;
                        $display("FAIL %s: rd_data=%h rd_err=%b expected rd_data=%h rd_err=%b",
                                 it.tag, rd_data, rd_err, it.d, it.e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Timestamp frozen through reset by system-management inhibit
        idle(3);
        rst_n = 1'b1;
        quiet("R1 outputs after reset");
        rd(A_TSC, 64'h0, 1'b0, "R1 timestamp reset");
        rd(A_EVT, 64'h0, 1'b0, "R1 event reset");
        idle(1);
        quiet("R10 bus idle after read");

        // R3 / R4: load while frozen under system-management
        wr(A_TSC, 64'hDEAD_BEEF_1234_5678);
        rd(A_TSC, 64'h0000_0000_1234_5678, 1'b0, "R3 high half cleared");
        idle(2);
        rd(A_TSC, 64'h0000_0000_1234_5678, 1'b0, "R4 held in system-management");

        mode_active = 3'b010; mode_hold = 3'b010;
        wr(A_TSC, 64'h77);
        idle(3);
        rd(A_TSC, 64'h77, 1'b0, "R4 held in debug");

        mode_active = 3'b100; mode_hold = 3'b100;
        wr(A_TSC, 64'h99);
        idle(2);
        rd(A_TSC, 64'h99, 1'b0, "R4 held in suspend");

        // R2 / R4 / R8: modes active but not inhibiting
        mode_active = 3'b111; mode_hold = 3'b000;
        wr(A_TSC, 64'h100);
        rd(A_TSC, 64'h100, 1'b0, "R8 timestamp write beats step");
        rd(A_TSC, 64'h101, 1'b0, "R2 one step per clock");
        idle(3);
        rd(A_TSC, 64'h105, 1'b0, "R2 steps across idle gap");

        // R4: hold bits set but no mode active
        mode_active = 3'b000; mode_hold = 3'b111;
        wr(A_TSC, 64'h200);
        idle(1);
        rd(A_TSC, 64'h201, 1'b0, "R4 hold bits without mode");

        mode_active = 3'b001; mode_hold = 3'b001;
        wr(A_TSC, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_TSC, 64'h0000_0000_FFFF_FFFF, 1'b0, "R3 all-ones write");

        // R5: qualified events
        evt_enable = 1'b1; evt_pulse = 1'b1;
        idle(4);
        evt_pulse = 1'b0;
        rd(A_EVT, 64'd4, 1'b0, "R5 enabled pulses");
        evt_enable = 1'b0; evt_pulse = 1'b1;
        idle(3);
        evt_pulse = 1'b0;
        rd(A_EVT, 64'd4, 1'b0, "R5 disabled pulses ignored");
        evt_enable = 1'b1;
        idle(2);
        rd(A_EVT, 64'd4, 1'b0, "R5 enable without pulse");

        // R6: reserved bits
        wr(A_EVT, 64'hABCD_EF12_3456_789A);
        rd(A_EVT, 64'h0000_0012_3456_789A, 1'b0, "R6 reserved bits dropped");

        // R7: wrap
        wr(A_EVT, 64'h0000_00FF_FFFF_FFFF);
        evt_pulse = 1'b1;
        idle(1);
        evt_pulse = 1'b0;
        rd(A_EVT, 64'h0, 1'b0, "R7 event wrap to zero");

        // R8: write and pulse in the same cycle
        evt_pulse = 1'b1;
        wr(A_EVT, 64'd5);
        evt_pulse = 1'b0;
        rd(A_EVT, 64'd5, 1'b0, "R8 event write beats pulse");

        // R9: unmapped reads, back to back with a mapped one
        rd(32'h11, 64'h0, 1'b1, "R9 unmapped 0x11");
        rd(32'h00, 64'h0, 1'b1, "R9 unmapped 0x00");
        rd(A_EVT, 64'd5, 1'b0, "R9 error clears on mapped read");
        idle(1);
        quiet("R9 error lasts one cycle");

        // R11: stray writes
        wr(32'h11, 64'h1234);
        wr(32'hC0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_EVT, 64'd5, 1'b0, "R11 event untouched");
        rd(A_TSC, 64'h0000_0000_FFFF_FFFF, 1'b0, "R11 timestamp untouched");

        idle(2);
        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R10: %0d reads without result, expected 0", sbq.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule